// File: doc/BRIEF.md
# Unaligned Transfer Bus Cycle Splitter

This block takes one load or store request at a time, as a byte or a 16-bit word at any byte address, and turns it into bus cycles on a 16-bit external bus. The bus has a word address, two active-low byte-lane enables, cycle-type signals and an address strobe. An aligned word or a single byte needs one bus cycle. A word at an odd address is split into two cycles, and the correct lanes are enabled in each.

Memory requests use a 24-bit byte space. I/O requests use a 16-bit space. Coprocessor requests are I/O cycles placed in a fixed window with bit 23 set, so that they lie outside programmed I/O.

Each bus cycle has an address state, in which the strobe is low, followed by one or more wait states in which the ready input is sampled. On reads, the block collects the lanes of one or both cycles and returns a single right-aligned 16-bit result.

The sequencer has five states:
- `ST_IDLE` accepts a request and moves to `ST_ADDR_A`.
- `ST_ADDR_A` always moves to `ST_WAIT_A`.
- `ST_WAIT_A` holds until ready is low. It then moves to `ST_ADDR_B` for a split word, or back to `ST_IDLE`.
- `ST_ADDR_B` always moves to `ST_WAIT_B`.
- `ST_WAIT_B` holds until ready is low and then returns to `ST_IDLE`.

Top module: `bus_split_unit`

## Requirements
- R1: `req_ready` is high exactly when no bus cycle is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The first bus cycle starts in the state right after that edge.
- R2: `bus_addr` carries the effective byte address shifted right by one. Address bit 0 appears only through the byte-lane enables.
- R3: A byte at an even address enables only the low lane (`bus_ble_n`=0, data bits 7..0). A byte at an odd address enables only the high lane (`bus_bhe_n`=0, bits 15..8). An even-address word enables both lanes, in a single cycle.
- R4: A word at odd byte address N takes two cycles. The first enables the high lane at word address N>>1. The second enables the low lane at the next word address, wrapping within the request's address space.
- R5: Every cycle lasts at least two states. `bus_ads_n` is low only in the first state. All bus outputs stay constant for the whole cycle. Ready (`bus_rdy_n`=0) is ignored in the first state. The cycle ends at the first later edge where ready is low.
- R6: `bus_mio` is 1 for memory and 0 for I/O. `bus_wr` is 1 for a write. `bus_dc` follows `req_data`.
- R7: For an I/O request (`req_io`=1, `req_cop`=0), only byte-address bits 15..0 are used and bits 23..16 are zero. For a coprocessor request (`req_cop`=1, always sent with `req_io`=1), the byte address is 0x8000F8 plus `req_addr[2:0]`.
- R8: Write data is steered onto the lanes.
  - An even byte goes on bits 7..0 and an odd byte on bits 15..8.
  - An aligned word goes out unchanged.
  - A split word sends its low byte on bits 15..8 in the first cycle and its high byte on bits 7..0 in the second.
  - Unused lanes, read cycles and idle states drive 0.
- R9: `rsp_valid` pulses for one state, the state right after the edge that ends the last cycle of a request. On reads, `rsp_rdata` holds the byte in bits 7..0 with zero above it, or the whole word in order. For a split word, the response comes only after both cycles.
- R10: Outside bus cycles and during reset, `bus_ads_n`, `bus_ble_n` and `bus_bhe_n` are 1, `bus_addr`, `bus_mio`, `bus_wr` and `bus_dc` are 0, and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request is taken this edge |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_io | input | 1 | 1 I/O space, 0 memory |
| req_cop | input | 1 | Coprocessor I/O window |
| req_data | input | 1 | 1 data cycle, 0 control cycle |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data, byte in bits 7..0 |
| rsp_valid | output | 1 | Request finished |
| rsp_rdata | output | 16 | Aligned read result |
| bus_addr | output | 23 | Word address (byte bits 23..1) |
| bus_ble_n | output | 1 | Low lane enable, active low |
| bus_bhe_n | output | 1 | High lane enable, active low |
| bus_mio | output | 1 | 1 memory, 0 I/O |
| bus_wr | output | 1 | 1 write, 0 read |
| bus_dc | output | 1 | 1 data, 0 control |
| bus_ads_n | output | 1 | Address strobe, active low |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| bus_rdy_n | input | 1 | Ready, active low |

## Verification
The hardest situation to reach is a split word at the very top of an address space, where the second cycle must wrap. Examples are I/O byte address 0xFFFF and memory byte address 0xFFFFFF, combined with wait states and with ready asserted early in the address state, where it must be ignored. Directed requests hit both wrap points, the coprocessor window and every lane case. They are followed by a pseudo-random stream whose per-cycle wait counts and early-ready pulses follow a fixed pattern, so that each split meets several stretch lengths. A behavioural model in the bench predicts every bus output and response, and it is compared on every clock.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_A,
        ST_WAIT_A,
        ST_ADDR_B,
        ST_WAIT_B
    } bsu_state_e;

    typedef struct packed {
        logic write;
        logic word;
        logic io;
        logic cop;
        logic data;
    } bsu_flags_t;

endpackage

// File: rtl/bsu_addr_gen.sv
module bsu_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 16,
    parameter logic [ADDR_W-1:0] COP_BASE = 'h8000F8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io,
    input  logic              cop,
    input  logic              word,
    output logic [ADDR_W-2:0] wa_first,
    output logic [ADDR_W-2:0] wa_second,
    output logic [1:0]        en_first_n,
    output logic [1:0]        en_second_n,
    output logic              odd,
    output logic              split
);
    localparam int WA_W    = ADDR_W - 1;
    localparam int IO_WA_W = IO_W - 1;

    logic [ADDR_W-1:0] eff;
    logic [WA_W-1:0]   inc;

    // effective byte address per space
    always_comb begin
        if (cop) begin
            eff = COP_BASE | {{(ADDR_W-3){1'b0}}, addr[2:0]};
        end else if (io) begin
            eff = {{(ADDR_W-IO_W){1'b0}}, addr[IO_W-1:0]};
        end else begin
            eff = addr;
        end
    end

    assign wa_first = eff[ADDR_W-1:1];
    assign odd      = eff[0];
    assign split    = word & eff[0];
    assign inc      = wa_first + {{(WA_W-1){1'b0}}, 1'b1};

    // second half wraps inside the request's own space
    always_comb begin
        if (io && !cop) begin
            wa_second = {{(WA_W-IO_WA_W){1'b0}}, inc[IO_WA_W-1:0]};
        end else begin
            wa_second = inc;
        end
    end

    // enables as {high_n, low_n}
    always_comb begin
        if (word && !eff[0]) begin
            en_first_n = 2'b00;
        end else if (eff[0]) begin
            en_first_n = 2'b01;
        end else begin
            en_first_n = 2'b10;
        end
        en_second_n = 2'b10;
    end

endmodule

// File: rtl/bsu_lane_steer.sv
module bsu_lane_steer #(
    parameter int DATA_W = 16
) (
    input  logic                write,
    input  logic                word,
    input  logic                odd,
    input  logic                second,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   din,
    input  logic [DATA_W/2-1:0] held_byte,
    output logic [DATA_W-1:0]   dout,
    output logic [DATA_W-1:0]   rd_word
);
    localparam int BYTE_W = DATA_W / 2;

    logic [BYTE_W-1:0] zero_b;
    logic [BYTE_W-1:0] w_lo;
    logic [BYTE_W-1:0] w_hi;
    logic [BYTE_W-1:0] d_lo;
    logic [BYTE_W-1:0] d_hi;

    assign zero_b = '0;
    assign w_lo   = wdata[BYTE_W-1:0];
    assign w_hi   = wdata[DATA_W-1:BYTE_W];
    assign d_lo   = din[BYTE_W-1:0];
    assign d_hi   = din[DATA_W-1:BYTE_W];

    // write steering
    always_comb begin
        if (!write) begin
            dout = '0;
        end else if (word && !odd) begin
            dout = wdata;
        end else if (word) begin
            dout = second ? {zero_b, w_hi} : {w_lo, zero_b};
        end else begin
            dout = odd ? {w_lo, zero_b} : {zero_b, w_lo};
        end
    end

    // read reassembly
    always_comb begin
        if (word && !odd) begin
            rd_word = din;
        end else if (word) begin
            rd_word = {d_lo, held_byte};
        end else begin
            rd_word = {zero_b, odd ? d_hi : d_lo};
        end
    end

endmodule

// File: rtl/bsu_seq.sv
module bsu_seq
    import bsu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                rdy_n,
    input  logic                split,
    input  logic                is_write,
    input  logic [DATA_W-1:0]   rd_word,
    input  logic [DATA_W/2-1:0] din_hi,
    output logic                req_ready,
    output logic                take,
    output logic                ads_n,
    output logic                in_cycle,
    output logic                second,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [DATA_W/2-1:0] held_byte
);
    bsu_state_e state_q;
    bsu_state_e state_d;
    logic       done;
    logic       hold_lo;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ADDR_A;
            ST_ADDR_A: state_d = ST_WAIT_A;
            ST_WAIT_A: if (!rdy_n) state_d = split ? ST_ADDR_B : ST_IDLE;
            ST_ADDR_B: state_d = ST_WAIT_B;
            ST_WAIT_B: if (!rdy_n) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // decoded outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        take      = req_ready && req_valid;
        ads_n     = !((state_q == ST_ADDR_A) || (state_q == ST_ADDR_B));
        in_cycle  = (state_q != ST_IDLE);
        second    = (state_q == ST_ADDR_B) || (state_q == ST_WAIT_B);
        done      = !rdy_n && (((state_q == ST_WAIT_A) && !split) || (state_q == ST_WAIT_B));
        hold_lo   = !rdy_n && (state_q == ST_WAIT_A) && split;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            held_byte <= '0;
        end else begin
            rsp_valid <= done;
            if (done) begin
                rsp_rdata <= is_write ? '0 : rd_word;
            end
            if (hold_lo) begin
                held_byte <= din_hi;
            end
        end
    end

endmodule

// File: rtl/bus_split_unit.sv
module bus_split_unit
    import bsu_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 16,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] COP_BASE = 'h8000F8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_word,
    input  logic              req_io,
    input  logic              req_cop,
    input  logic              req_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-2:0] bus_addr,
    output logic              bus_ble_n,
    output logic              bus_bhe_n,
    output logic              bus_mio,
    output logic              bus_wr,
    output logic              bus_dc,
    output logic              bus_ads_n,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_rdy_n
);
    localparam int WA_W   = ADDR_W - 1;
    localparam int BYTE_W = DATA_W / 2;

    bsu_flags_t        flags_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    logic [WA_W-1:0]   wa_first;
    logic [WA_W-1:0]   wa_second;
    logic [1:0]        en_first_n;
    logic [1:0]        en_second_n;
    logic              odd;
    logic              split;
    logic              take;
    logic              in_cycle;
    logic              second;
    logic              ads_n;
    logic [DATA_W-1:0] lane_dout;
    logic [DATA_W-1:0] rd_word;
    logic [BYTE_W-1:0] held_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take) begin
            flags_q <= '{write: req_write, word: req_word, io: req_io | req_cop,
                         cop: req_cop, data: req_data};
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    bsu_addr_gen #(
        .ADDR_W   (ADDR_W),
        .IO_W     (IO_W),
        .COP_BASE (COP_BASE)
    ) u_addr (
        .addr        (addr_q),
        .io          (flags_q.io),
        .cop         (flags_q.cop),
        .word        (flags_q.word),
        .wa_first    (wa_first),
        .wa_second   (wa_second),
        .en_first_n  (en_first_n),
        .en_second_n (en_second_n),
        .odd         (odd),
        .split       (split)
    );

    bsu_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rdy_n     (bus_rdy_n),
        .split     (split),
        .is_write  (flags_q.write),
        .rd_word   (rd_word),
        .din_hi    (bus_din[DATA_W-1:BYTE_W]),
        .req_ready (req_ready),
        .take      (take),
        .ads_n     (ads_n),
        .in_cycle  (in_cycle),
        .second    (second),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .held_byte (held_byte)
    );

    bsu_lane_steer #(
        .DATA_W (DATA_W)
    ) u_lane (
        .write     (flags_q.write),
        .word      (flags_q.word),
        .odd       (odd),
        .second    (second),
        .wdata     (wdata_q),
        .din       (bus_din),
        .held_byte (held_byte),
        .dout      (lane_dout),
        .rd_word   (rd_word)
    );

    // bus pins: cycle fields while active, idle levels otherwise
    always_comb begin
        bus_ads_n = ads_n;
        if (in_cycle) begin
            bus_addr  = second ? wa_second : wa_first;
            {bus_bhe_n, bus_ble_n} = second ? en_second_n : en_first_n;
            bus_mio   = !flags_q.io;
            bus_wr    = flags_q.write;
            bus_dc    = flags_q.data;
            bus_dout  = lane_dout;
        end else begin
            bus_addr  = '0;
            bus_bhe_n = 1'b1;
            bus_ble_n = 1'b1;
            bus_mio   = 1'b0;
            bus_wr    = 1'b0;
            bus_dc    = 1'b0;
            bus_dout  = '0;
        end
    end

endmodule

// File: rtl/bsu_chk.sv
module bsu_chk #(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-2:0] bus_addr,
    input logic              bus_ble_n,
    input logic              bus_bhe_n,
    input logic              bus_mio,
    input logic              bus_wr,
    input logic              bus_dc,
    input logic              bus_ads_n,
    input logic [DATA_W-1:0] bus_dout,
    input logic              bus_rdy_n
);
    localparam int WA_W = ADDR_W - 1;

    // R5
    ads_one_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |=> bus_ads_n);

    // R5
    cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |=> ($stable(bus_addr) && $stable(bus_ble_n) && $stable(bus_bhe_n)
                        && $stable(bus_mio) && $stable(bus_wr) && $stable(bus_dc)
                        && $stable(bus_dout)));

    // R3
    lane_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |-> !(bus_ble_n && bus_bhe_n));

    // R1
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |-> !req_ready);

    // R9
    rsp_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!bus_rdy_n));

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    io_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ads_n && !bus_mio && !bus_addr[WA_W-1]) |-> (bus_addr[WA_W-1:IO_W-1] == '0));

    // R10
    idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_ble_n && bus_bhe_n && bus_ads_n));

endmodule

bind bus_split_unit bsu_chk #(
    .ADDR_W (ADDR_W),
    .IO_W   (IO_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_addr  (bus_addr),
    .bus_ble_n (bus_ble_n),
    .bus_bhe_n (bus_bhe_n),
    .bus_mio   (bus_mio),
    .bus_wr    (bus_wr),
    .bus_dc    (bus_dc),
    .bus_ads_n (bus_ads_n),
    .bus_dout  (bus_dout),
    .bus_rdy_n (bus_rdy_n)
);

// File: tb/bus_split_unit_tb.sv
module bus_split_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic        req_io = 1'b0;
    logic        req_cop = 1'b0;
    logic        req_data = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [22:0] bus_addr;
    logic        bus_ble_n, bus_bhe_n, bus_mio, bus_wr, bus_dc, bus_ads_n;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_rdy_n = 1'b1;

    always #2 clk = ~clk;

    bus_split_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word), .req_io(req_io), .req_cop(req_cop),
        .req_data(req_data), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_ble_n(bus_ble_n), .bus_bhe_n(bus_bhe_n), .bus_mio(bus_mio), .bus_wr(bus_wr),
        .bus_dc(bus_dc), .bus_ads_n(bus_ads_n), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_rdy_n(bus_rdy_n)
    );

    typedef struct packed {
        logic wr; logic word; logic io; logic cop; logic dc;
        logic [23:0] a; logic [15:0] wd;
    } breq_t;

    typedef struct packed {
        logic [22:0] wa; logic ble_n; logic bhe_n; logic [15:0] dout;
    } part_t;

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // bench memory image: word content derived from word address
    function automatic logic [15:0] pat(input logic [22:0] wa);
        logic [7:0] hi, lo;
        hi = wa[7:0] ^ 8'h3C ^ wa[22:15];
        lo = wa[15:8] + wa[7:0] + 8'h11;
        return {hi, lo};
    endfunction

    function automatic void mk_parts(input breq_t r, output part_t p0, output part_t p1,
                                     output int n, output logic [15:0] rexp);
        logic [23:0] e;
        logic [22:0] w0, w1;
        logic [15:0] m0, m1;
        if (r.cop) e = 24'h8000F8 + {21'd0, r.a[2:0]};
        else if (r.io) e = {8'd0, r.a[15:0]};
        else e = r.a;
        w0 = e[23:1];
        w1 = w0 + 23'd1;
        if (r.io && !r.cop) w1 = w1 & 23'h7FFF;
        m0 = pat(w0);
        m1 = pat(w1);
        p1 = '0;
        if (!r.word) begin
            n = 1;
            p0.wa = w0; p0.ble_n = e[0]; p0.bhe_n = !e[0];
            p0.dout = !r.wr ? 16'h0 : (e[0] ? {r.wd[7:0], 8'h00} : {8'h00, r.wd[7:0]});
            rexp = {8'h00, e[0] ? m0[15:8] : m0[7:0]};
        end else if (!e[0]) begin
            n = 1;
            p0.wa = w0; p0.ble_n = 1'b0; p0.bhe_n = 1'b0;
            p0.dout = r.wr ? r.wd : 16'h0;
            rexp = m0;
        end else begin
            n = 2;
            p0.wa = w0; p0.ble_n = 1'b1; p0.bhe_n = 1'b0;
            p0.dout = r.wr ? {r.wd[7:0], 8'h00} : 16'h0;
            p1.wa = w1; p1.ble_n = 1'b0; p1.bhe_n = 1'b1;
            p1.dout = r.wr ? {8'h00, r.wd[15:8]} : 16'h0;
            rexp = {m1[7:0], m0[15:8]};
        end
    endfunction

    breq_t stim[$];
    part_t cur[$];

    function automatic breq_t mkr(input bit wr, input bit word, input bit io, input bit cop,
                                  input bit dc, input logic [23:0] a, input logic [15:0] wd);
        breq_t r;
        r.wr = wr; r.word = word; r.io = io | cop; r.cop = cop; r.dc = dc; r.a = a; r.wd = wd;
        return r;
    endfunction

    initial begin
        int ph;
        int wcnt;
        int cyc_idx;
        int tick;
        bit rsp_pend;
        bit rsp_rd;
        logic [15:0] rsp_exp;
        breq_t act;
        logic [31:0] lfsr;
        int guard;

        // directed cases
        stim.push_back(mkr(0, 1, 0, 0, 1, 24'h001234, 0));        // R3 aligned word read
        stim.push_back(mkr(1, 1, 0, 0, 1, 24'h002000, 16'hBEEF)); // R8 aligned word write
        stim.push_back(mkr(0, 0, 0, 0, 1, 24'h000410, 0));        // R3 even byte read
        stim.push_back(mkr(0, 0, 0, 0, 0, 24'h000411, 0));        // R3 odd byte read, control
        stim.push_back(mkr(1, 0, 0, 0, 1, 24'h000411, 16'h00A7)); // R8 odd byte write
        stim.push_back(mkr(1, 0, 0, 0, 1, 24'h000410, 16'h005C)); // R8 even byte write
        stim.push_back(mkr(0, 1, 0, 0, 1, 24'h123457, 0));        // R4 split read
        stim.push_back(mkr(1, 1, 0, 0, 1, 24'h00ABCD, 16'h1234)); // R4 R8 split write
        stim.push_back(mkr(0, 1, 0, 0, 1, 24'hFFFFFF, 0));        // R4 memory wrap
        stim.push_back(mkr(0, 1, 1, 0, 1, 24'hA5FFFF, 0));        // R7 R4 io wrap
        stim.push_back(mkr(1, 1, 1, 0, 1, 24'h7F0301, 16'h55AA)); // R7 io split write
        stim.push_back(mkr(0, 0, 1, 1, 0, 24'h000003, 0));        // R7 coprocessor byte
        stim.push_back(mkr(0, 1, 1, 1, 0, 24'h000007, 0));        // R7 coprocessor split
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 120; i++) begin
            breq_t r;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            r = mkr(lfsr[0], lfsr[1], lfsr[2] & lfsr[3], (lfsr[4:2] == 3'b111), lfsr[5],
                    lfsr[29:6], lfsr[31:16]);
            stim.push_back(r);
        end

        // reset state, R10
        repeat (3) @(negedge clk);
        chk(bus_ads_n == 1'b1, "R10", "ads_n in reset", bus_ads_n, 1);
        chk(bus_ble_n && bus_bhe_n, "R10", "enables in reset", {bus_bhe_n, bus_ble_n}, 3);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", rsp_valid, 0);
        chk(bus_addr == 0, "R10", "addr in reset", bus_addr, 0);
        rst_n = 1'b1;

        ph = 0; wcnt = 0; cyc_idx = 0; tick = 0; rsp_pend = 0; rsp_rd = 0; rsp_exp = 0;
        act = '0;
        guard = 0;
        while ((stim.size() > 0 || ph != 0 || rsp_pend) && guard < 50000) begin
            @(negedge clk);
            guard++;
            tick++;
            // compare against model
            chk(req_ready == (ph == 0), "R1", "req_ready", req_ready, ph == 0);
            chk(bus_ads_n == (ph != 1), "R5", "ads_n", bus_ads_n, ph != 1);
            if (ph != 0) begin
                chk(bus_addr == cur[0].wa, "R2", "word address", bus_addr, cur[0].wa);
                chk(bus_ble_n == cur[0].ble_n, "R3", "ble_n", bus_ble_n, cur[0].ble_n);
                chk(bus_bhe_n == cur[0].bhe_n, "R4", "bhe_n", bus_bhe_n, cur[0].bhe_n);
                chk(bus_mio == !act.io, "R6", "mio", bus_mio, !act.io);
                chk(bus_wr == act.wr, "R6", "wr", bus_wr, act.wr);
                chk(bus_dc == act.dc, "R6", "dc", bus_dc, act.dc);
                chk(bus_dout == cur[0].dout, "R8", "dout", bus_dout, cur[0].dout);
            end else begin
                chk(bus_ble_n && bus_bhe_n && bus_addr == 0 && !bus_mio && !bus_wr && !bus_dc
                    && bus_dout == 0, "R10", "idle bus",
                    {bus_addr, bus_bhe_n, bus_ble_n}, 3);
            end
            chk(rsp_valid == rsp_pend, "R9", "rsp_valid", rsp_valid, rsp_pend);
            if (rsp_pend && rsp_rd) begin
                chk(rsp_rdata == rsp_exp, "R9", "rsp_rdata", rsp_rdata, rsp_exp);
            end

            // drive next inputs
            if (stim.size() > 0 && (tick % 7) != 3) begin
                req_valid = 1'b1;
                req_write = stim[0].wr; req_word = stim[0].word; req_io = stim[0].io;
                req_cop = stim[0].cop; req_data = stim[0].dc;
                req_addr = stim[0].a; req_wdata = stim[0].wd;
            end else begin
                req_valid = 1'b0;
                req_addr = 24'h5A5A5A;
            end
            if (ph == 2) bus_rdy_n = (wcnt > 0);
            else if (ph == 1) bus_rdy_n = (cyc_idx % 3) != 0;   // R5 early ready ignored
            else bus_rdy_n = tick[0];
            bus_din = (ph != 0) ? pat(bus_addr) : 16'hDEAD;

            // advance model to the next edge
            rsp_pend = 0;
            if (ph == 0) begin
                if (req_valid) begin
                    part_t p0, p1;
                    int n;
                    act = stim.pop_front();
                    mk_parts(act, p0, p1, n, rsp_exp);
                    cur.push_back(p0);
                    if (n == 2) cur.push_back(p1);
                    rsp_rd = !act.wr;
                    ph = 1;
                end
            end else if (ph == 1) begin
                ph = 2;
                wcnt = (cyc_idx * 5 + 1) % 4;
                cyc_idx++;
            end else begin
                if (!bus_rdy_n) begin
                    void'(cur.pop_front());
                    if (cur.size() > 0) begin
                        ph = 1;
                    end else begin
                        ph = 0;
                        rsp_pend = 1;
                    end
                end else begin
                    wcnt--;
                end
            end
        end
        if (guard >= 50000) begin
            chk(1'b0, "R1", "watchdog expired", guard, 0);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule